// File: doc/BRIEF.md
# Configurable Programmable-Logic Storage Cell

This block is the storage cell that sits behind a sum-of-products term in a programmable logic block. It takes one product-sum data bit and gives one output bit toward the routing fabric. Configuration inputs choose what the cell is: a D flip-flop, a T flip-flop, a transparent latch, or a plain combinational path. They also choose where its clock comes from, which polarity that clock has, how it is initialised, and whether reset and preset trade places.

Two modes exist, and they differ only in clocking and initialisation. Synchronous mode uses one of four clocks shared by the block, together with a block-wide reset term and a block-wide preset term. Asynchronous mode uses one of two block clocks or the cell's own product-term clock, in either polarity, and one private initialisation term that configuration turns into either a reset or a preset. The data path is identical in both modes.

Everything is sampled on one system clock `clk`. A "clock edge" of the selected cell clock means that the cell clock was at its inactive level at the previous `clk` rising edge and is at its active level at this one. Reset, preset and initialisation terms act on the next `clk` edge, whatever the cell clock is doing. Element codes on `cfgElem` are 0 = D flip-flop, 1 = T flip-flop, 2 = latch, 3 = combinational bypass.

Top module: `pld_macrocell_reg`

## Requirements
- R1: With `cfgElem`=3, `cellOut` equals `sopIn` XOR `cfgDataInvert` in the same cycle, in either mode, with no clock needed.
- R2: With `cfgElem`=0, on a cell-clock active edge the stored bit takes `sopIn` XOR `cfgDataInvert`. The stored bit appears on `cellOut` right after that `clk` edge and holds when no edge occurs.
- R3: With `cfgElem`=1, an active edge inverts the stored bit when the polarity-adjusted data is 1 and leaves it unchanged when that data is 0.
- R4: With `cfgElem`=2, at every `clk` edge where the cell clock is at its active level the stored bit takes the polarity-adjusted data. While the cell clock is at its inactive level the stored bit holds.
- R5: In synchronous mode (`cfgAsyncMode`=0) the cell clock is `blkClk[cfgClkSel]`, always active-high. `ptClk` and `cfgClkInvert` have no effect.
- R6: In asynchronous mode, `cfgClkSel` selects the cell clock: 0 picks `blkClk[0]`, 1 picks `blkClk[1]`, and 2 or 3 pick `ptClk`. `cfgClkInvert`=1 makes the low level active, so the falling edge becomes the active edge.
- R7: In synchronous mode, `blkReset` clears the stored bit and `blkPreset` sets it. Reset wins when both are asserted, and `ptInit` has no effect.
- R8: In asynchronous mode, `ptInit` sets the stored bit when `cfgInitAsPreset`=1 and clears it otherwise. `blkReset` and `blkPreset` have no effect.
- R9: `cfgSwap`=1 exchanges the set and clear actions of whichever initialisation terms the mode uses.
- R10: While `rstPor` is high the stored bit loads 1 exactly when the cell is configured to set from its control term, that is `cfgSwap` XOR (`cfgAsyncMode` AND `cfgInitAsPreset`), and loads 0 otherwise. The cell clock is treated as already active, so a clock held at its active level through power-up gives no edge.
- R11: `cfgDataInvert` inverts the data seen by every element type.
- R12: An active reset or preset overrides a simultaneous clock edge or transparent latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstPor | input | 1 | Power-on reset, active high, synchronous |
| cfgAsyncMode | input | 1 | 0 = synchronous mode, 1 = asynchronous mode |
| cfgElem | input | 2 | Element type: 0 D, 1 T, 2 latch, 3 bypass |
| cfgClkSel | input | 2 | Cell clock selection |
| cfgClkInvert | input | 1 | Active-low cell clock (asynchronous mode only) |
| cfgSwap | input | 1 | Exchange reset and preset |
| cfgInitAsPreset | input | 1 | Private init term acts as preset (asynchronous mode) |
| cfgDataInvert | input | 1 | Invert data input |
| blkClk | input | 4 | Shared block clocks |
| ptClk | input | 1 | Private product-term clock |
| blkReset | input | 1 | Shared block reset term |
| blkPreset | input | 1 | Shared block preset term |
| ptInit | input | 1 | Private initialisation term |
| sopIn | input | 1 | Sum-of-products data |
| cellOut | output | 1 | Cell output |

## Verification
Directed sequences drive each element type with data that differs from the stored bit before the edge. This way, a load, a toggle and a hold each give a different output. Clocks that are not selected get edges while the selected one stays still, and the inverted clock polarity is tried on a falling edge, so a wrong clock mux shows up. Init terms are applied in both modes, with and without swap, including both terms together and a term against a clock edge, and power-up runs through each configuration that sets. A long pseudo-random phase then varies every input and configuration bit against a behavioural model.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    ELEM_DFF   = 2'd0,
    ELEM_TFF   = 2'd1,
    ELEM_LATCH = 2'd2,
    ELEM_COMB  = 2'd3
  } elemKind_t;

  typedef struct packed {
    logic porLoad;
    logic porHigh;
    logic forceLow;
    logic forceHigh;
    logic loadEn;
    logic toggleEn;
    logic bypass;
  } cellStrobes_t;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
#(
  parameter int NUM_BLK_CLK = 4,
  localparam int SEL_W = $clog2(NUM_BLK_CLK)
) (
  input  logic                   clk,
  input  logic                   rstPor,
  input  logic                   cfgAsyncMode,
  input  logic [1:0]             cfgElem,
  input  logic [SEL_W-1:0]       cfgClkSel,
  input  logic                   cfgClkInvert,
  input  logic                   cfgSwap,
  input  logic                   cfgInitAsPreset,
  input  logic [NUM_BLK_CLK-1:0] blkClk,
  input  logic                   ptClk,
  input  logic                   blkReset,
  input  logic                   blkPreset,
  input  logic                   ptInit,
  output cellStrobes_t           strobes
);
  logic rawLvl;
  logic actLvl;
  logic prevLvl;
  logic activeEdge;
  logic rawClr;
  logic rawSet;
  logic effClr;
  logic effSet;
  elemKind_t elemKind;

  assign elemKind = elemKind_t'(cfgElem);

  // Clock source: the synchronous set is every block clock, the asynchronous
  // set is the two lowest block clocks plus the private term clock.
  always_comb begin
    if (!cfgAsyncMode) begin
      rawLvl = blkClk[cfgClkSel];
      actLvl = rawLvl;
    end else begin
      if (cfgClkSel >= SEL_W'(2)) rawLvl = ptClk;
      else                        rawLvl = blkClk[cfgClkSel[0]];
      actLvl = rawLvl ^ cfgClkInvert;
    end
  end

  always_ff @(posedge clk) begin
    if (rstPor) prevLvl <= 1'b1;
    else        prevLvl <= actLvl;
  end

  assign activeEdge = actLvl & ~prevLvl;

  // Initialisation sources per mode, then the per-cell swap.
  always_comb begin
    if (!cfgAsyncMode) begin
      rawClr = blkReset;
      rawSet = blkPreset;
    end else begin
      rawClr = ptInit & ~cfgInitAsPreset;
      rawSet = ptInit &  cfgInitAsPreset;
    end
    effClr = cfgSwap ? rawSet : rawClr;
    effSet = cfgSwap ? rawClr : rawSet;
  end

  always_comb begin
    strobes.porLoad   = rstPor;
    strobes.porHigh   = cfgSwap ^ (cfgAsyncMode & cfgInitAsPreset);
    strobes.forceLow  = effClr;
    strobes.forceHigh = effSet & ~effClr;
    strobes.loadEn    = ((elemKind == ELEM_DFF) & activeEdge) |
                        ((elemKind == ELEM_LATCH) & actLvl);
    strobes.toggleEn  = (elemKind == ELEM_TFF) & activeEdge;
    strobes.bypass    = (elemKind == ELEM_COMB);
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
(
  input  logic         clk,
  input  cellStrobes_t strobes,
  input  logic         sopIn,
  input  logic         cfgDataInvert,
  output logic         cellOut
);
  logic dataAdj;
  logic stateQ;

  assign dataAdj = sopIn ^ cfgDataInvert;

  always_ff @(posedge clk) begin
    if (strobes.porLoad)                  stateQ <= strobes.porHigh;
    else if (strobes.forceLow)            stateQ <= 1'b0;
    else if (strobes.forceHigh)           stateQ <= 1'b1;
    else if (strobes.loadEn)              stateQ <= dataAdj;
    else if (strobes.toggleEn && dataAdj) stateQ <= ~stateQ;
  end

  assign cellOut = strobes.bypass ? dataAdj : stateQ;
endmodule

// File: rtl/pld_macrocell_reg.sv
module pld_macrocell_reg
  import mc_pkg::*;
#(
  parameter int NUM_BLK_CLK = 4,
  localparam int SEL_W = $clog2(NUM_BLK_CLK)
) (
  input  logic                   clk,
  input  logic                   rstPor,
  input  logic                   cfgAsyncMode,
  input  logic [1:0]             cfgElem,
  input  logic [SEL_W-1:0]       cfgClkSel,
  input  logic                   cfgClkInvert,
  input  logic                   cfgSwap,
  input  logic                   cfgInitAsPreset,
  input  logic                   cfgDataInvert,
  input  logic [NUM_BLK_CLK-1:0] blkClk,
  input  logic                   ptClk,
  input  logic                   blkReset,
  input  logic                   blkPreset,
  input  logic                   ptInit,
  input  logic                   sopIn,
  output logic                   cellOut
);
  cellStrobes_t strobes;

  mc_ctrl #(.NUM_BLK_CLK(NUM_BLK_CLK)) ctrl_i (
    .clk(clk), .rstPor(rstPor), .cfgAsyncMode(cfgAsyncMode), .cfgElem(cfgElem),
    .cfgClkSel(cfgClkSel), .cfgClkInvert(cfgClkInvert), .cfgSwap(cfgSwap),
    .cfgInitAsPreset(cfgInitAsPreset), .blkClk(blkClk), .ptClk(ptClk),
    .blkReset(blkReset), .blkPreset(blkPreset), .ptInit(ptInit),
    .strobes(strobes)
  );

  mc_datapath dp_i (
    .clk(clk), .strobes(strobes), .sopIn(sopIn),
    .cfgDataInvert(cfgDataInvert), .cellOut(cellOut)
  );
endmodule

// File: rtl/mc_checker.sv
module mc_checker (
  input logic       clk,
  input logic       rstPor,
  input logic       cfgAsyncMode,
  input logic [1:0] cfgElem,
  input logic       cfgSwap,
  input logic       cfgInitAsPreset,
  input logic       blkReset,
  input logic       blkPreset,
  input logic       ptInit,
  input logic       cellOut
);
  // R7
  sync_reset_clears_chk: assert property (@(posedge clk) disable iff (rstPor)
    (!cfgAsyncMode && !cfgSwap && blkReset) |=> (cfgElem == 2'd3 || cellOut == 1'b0));

  // R7
  sync_preset_sets_chk: assert property (@(posedge clk) disable iff (rstPor)
    (!cfgAsyncMode && !cfgSwap && blkPreset && !blkReset) |=> (cfgElem == 2'd3 || cellOut == 1'b1));

  // R9
  swapped_reset_sets_chk: assert property (@(posedge clk) disable iff (rstPor)
    (!cfgAsyncMode && cfgSwap && blkReset && !blkPreset) |=> (cfgElem == 2'd3 || cellOut == 1'b1));

  // R8
  async_init_clear_chk: assert property (@(posedge clk) disable iff (rstPor)
    (cfgAsyncMode && !cfgSwap && !cfgInitAsPreset && ptInit) |=> (cfgElem == 2'd3 || cellOut == 1'b0));

  // R8
  async_init_set_chk: assert property (@(posedge clk) disable iff (rstPor)
    (cfgAsyncMode && !cfgSwap && cfgInitAsPreset && ptInit) |=> (cfgElem == 2'd3 || cellOut == 1'b1));
endmodule

bind pld_macrocell_reg mc_checker chk_i (
  .clk(clk), .rstPor(rstPor), .cfgAsyncMode(cfgAsyncMode), .cfgElem(cfgElem),
  .cfgSwap(cfgSwap), .cfgInitAsPreset(cfgInitAsPreset), .blkReset(blkReset),
  .blkPreset(blkPreset), .ptInit(ptInit), .cellOut(cellOut)
);

// File: tb/pld_macrocell_reg_tb_top.sv
`timescale 1ns/1ps
module pld_macrocell_reg_tb_top;
  logic       clk = 1'b0;
  logic       rstPor = 1'b1;
  logic       cfgAsyncMode = 0, cfgClkInvert = 0, cfgSwap = 0, cfgInitAsPreset = 0, cfgDataInvert = 0;
  logic [1:0] cfgElem = 0, cfgClkSel = 0;
  logic [3:0] blkClk = 0;
  logic       ptClk = 0, blkReset = 0, blkPreset = 0, ptInit = 0, sopIn = 0;
  logic       cellOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pld_macrocell_reg dut_i (
    .clk(clk), .rstPor(rstPor), .cfgAsyncMode(cfgAsyncMode), .cfgElem(cfgElem),
    .cfgClkSel(cfgClkSel), .cfgClkInvert(cfgClkInvert), .cfgSwap(cfgSwap),
    .cfgInitAsPreset(cfgInitAsPreset), .cfgDataInvert(cfgDataInvert),
    .blkClk(blkClk), .ptClk(ptClk), .blkReset(blkReset), .blkPreset(blkPreset),
    .ptInit(ptInit), .sopIn(sopIn), .cellOut(cellOut)
  );

  // Behavioural reference model.
  int  mState = 0;
  int  mPrevActive = 1;

  function automatic int modelLevel();
    int lv;
    if (cfgAsyncMode == 0) return int'(blkClk[cfgClkSel]);
    case (cfgClkSel)
      2'd0:    lv = blkClk[0];
      2'd1:    lv = blkClk[1];
      default: lv = ptClk;
    endcase
    if (cfgClkInvert) lv = 1 - lv;
    return lv;
  endfunction

  always @(posedge clk) begin
    int lv, d, clr, set, tmp;
    bit rising;
    lv = modelLevel();
    d  = int'(sopIn ^ cfgDataInvert);
    if (rstPor) begin
      mState = (cfgSwap ^ (cfgAsyncMode & cfgInitAsPreset)) ? 1 : 0;
      mPrevActive = 1;
    end else begin
      rising = (lv == 1) && (mPrevActive == 0);
      mPrevActive = lv;
      if (cfgAsyncMode) begin
        clr = (ptInit && !cfgInitAsPreset) ? 1 : 0;
        set = (ptInit &&  cfgInitAsPreset) ? 1 : 0;
      end else begin
        clr = int'(blkReset);
        set = int'(blkPreset);
      end
      if (cfgSwap) begin tmp = clr; clr = set; set = tmp; end
      if (clr != 0)      mState = 0;
      else if (set != 0) mState = 1;
      else case (cfgElem)
        2'd0: if (rising) mState = d;
        2'd1: if (rising && d == 1) mState = 1 - mState;
        2'd2: if (lv == 1) mState = d;
        default: ;
      endcase
    end
  end

  function automatic logic modelOut();
    if (cfgElem == 2'd3) return sopIn ^ cfgDataInvert;
    return logic'(mState[0]);
  endfunction

  task automatic chk(string tag, logic expVal);
    checks++;
    if (cellOut !== expVal) begin
      failures++;
      $display("FAIL %s: cellOut=%b expected=%b at %0t", tag, cellOut, expVal, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      chk("MODEL", modelOut());
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL WATCHDOG: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R10 power-up clears in plain synchronous configuration
    tick(2); rstPor = 0; tick(1); chk("R10", 1'b0);

    // R2 D flop on block clock 2
    cfgClkSel = 2; sopIn = 1; blkClk[2] = 1; tick(1); chk("R2", 1'b1);
    sopIn = 0; tick(1); chk("R2", 1'b1);
    blkClk[2] = 0; tick(1); blkClk[2] = 1; tick(1); chk("R2", 1'b0);

    // R5 unselected clocks and ptClk ignored, invert ignored in sync mode
    sopIn = 1; blkClk[0] = 1; blkClk[1] = 1; blkClk[3] = 1; ptClk = 1; tick(1);
    blkClk[0] = 0; blkClk[1] = 0; blkClk[3] = 0; ptClk = 0; tick(1); chk("R5", 1'b0);
    cfgClkInvert = 1; blkClk[2] = 0; tick(1); chk("R5", 1'b0);
    blkClk[2] = 1; tick(1); chk("R5", 1'b1); cfgClkInvert = 0;

    // R11 data polarity on the D flop
    cfgDataInvert = 1; blkClk[2] = 0; tick(1); blkClk[2] = 1; tick(1); chk("R11", 1'b0);
    cfgDataInvert = 0;

    // R3 T flop
    cfgElem = 1; sopIn = 1;
    blkClk[2] = 0; tick(1); blkClk[2] = 1; tick(1); chk("R3", 1'b1);
    blkClk[2] = 0; tick(1); blkClk[2] = 1; tick(1); chk("R3", 1'b0);
    sopIn = 0; blkClk[2] = 0; tick(1); blkClk[2] = 1; tick(1); chk("R3", 1'b0);
    sopIn = 1; blkClk[2] = 0; tick(1); blkClk[2] = 1; tick(1); chk("R3", 1'b1);
    cfgDataInvert = 1; blkClk[2] = 0; tick(1); blkClk[2] = 1; tick(1); chk("R11", 1'b1);
    cfgDataInvert = 0;

    // R4 latch
    cfgElem = 2; sopIn = 0; blkClk[2] = 0; tick(1); chk("R4", 1'b1);
    blkClk[2] = 1; tick(1); chk("R4", 1'b0);
    sopIn = 1; tick(1); chk("R4", 1'b1);
    blkClk[2] = 0; sopIn = 0; tick(1); chk("R4", 1'b1);

    // R1 combinational bypass
    cfgElem = 3; sopIn = 1; #1 chk("R1", 1'b1);
    sopIn = 0; #1 chk("R1", 1'b0);
    cfgDataInvert = 1; #1 chk("R1", 1'b1);
    cfgDataInvert = 0; tick(1);

    // R6 asynchronous mode, private clock, active low
    cfgAsyncMode = 1; cfgElem = 0; cfgClkSel = 2; cfgClkInvert = 1; sopIn = 0;
    ptClk = 1; tick(1); ptClk = 0; tick(1); chk("R6", 1'b0);
    sopIn = 1; ptClk = 1; tick(1); chk("R6", 1'b0);
    ptClk = 0; tick(1); chk("R6", 1'b1);
    cfgClkInvert = 0; cfgClkSel = 1; sopIn = 0;
    blkClk[2] = 1; tick(1); chk("R6", 1'b1);
    blkClk[1] = 1; tick(1); chk("R6", 1'b0);

    // R8 private init term
    cfgInitAsPreset = 1; ptInit = 1; tick(1); chk("R8", 1'b1);
    ptInit = 0; cfgInitAsPreset = 0; tick(1); ptInit = 1; tick(1); chk("R8", 1'b0);
    ptInit = 0; blkPreset = 1; tick(1); chk("R8", 1'b0);
    blkPreset = 0;

    // R7 shared block terms
    cfgAsyncMode = 0; cfgClkSel = 0; blkClk = 4'b0001;
    blkPreset = 1; tick(1); chk("R7", 1'b1);
    blkReset = 1; tick(1); chk("R7", 1'b0);
    blkReset = 0; tick(1); chk("R7", 1'b1);
    blkPreset = 0; ptInit = 1; cfgInitAsPreset = 0; tick(1); chk("R7", 1'b1);
    ptInit = 0;

    // R9 swap
    cfgSwap = 1; blkReset = 1; tick(1); blkReset = 0; tick(1); chk("R9", 1'b1);
    blkPreset = 1; tick(1); chk("R9", 1'b0);
    blkPreset = 0; cfgAsyncMode = 1; ptInit = 1; tick(1); chk("R9", 1'b1);
    ptInit = 0; cfgAsyncMode = 0; cfgSwap = 0;

    // R12 reset beats clock edge
    cfgClkSel = 2; sopIn = 1; blkReset = 1; blkClk[2] = 0; tick(1);
    blkClk[2] = 1; tick(1); chk("R12", 1'b0);
    blkReset = 0; tick(1); chk("R12", 1'b0);

    // R10 power-up values and no edge out of power-up
    cfgSwap = 1; rstPor = 1; tick(2); chk("R10", 1'b1);
    cfgSwap = 0; cfgAsyncMode = 1; cfgInitAsPreset = 1; tick(1); chk("R10", 1'b1);
    cfgInitAsPreset = 0; tick(1); chk("R10", 1'b0);
    cfgAsyncMode = 0; blkClk[2] = 1; sopIn = 1; tick(1);
    rstPor = 0; tick(1); chk("R10", 1'b0);

    // Pseudo-random phase against the model
    lfsr = 16'hACE1;
    for (int k = 0; k < 2000; k++) begin
      for (int s = 0; s < 16; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sopIn = lfsr[0]; blkClk = lfsr[4:1]; ptClk = lfsr[5];
      blkReset = (lfsr[8:6] == 3'd0); blkPreset = (lfsr[11:9] == 3'd0);
      ptInit = (lfsr[14:12] == 3'd0);
      if (k % 37 == 0) begin
        cfgAsyncMode = lfsr[15]; cfgElem = lfsr[2:1]; cfgClkSel = lfsr[7:6];
        cfgClkInvert = lfsr[9]; cfgSwap = (lfsr[11:10] == 2'd0);
        cfgInitAsPreset = lfsr[12]; cfgDataInvert = lfsr[13];
      end
      rstPor = (k % 500 == 250);
      tick(1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule